// File: doc/BRIEF.md
# GCM Counter Block Generator

This block produces the 128-bit counter blocks that a block cipher encrypts inside a Galois/Counter Mode datapath. The block is a single 128-bit register. Its upper part holds a 96-bit initialization vector and its lower 32 bits hold a block counter. Four one-cycle commands update the register. A clear sets every bit to zero, and encrypting that all-zero block yields the hash key. A data load writes the IV with the suffix 2, which is the first counter used for payload, so no separate increment cycle follows the load. A tag load writes the IV with the suffix 1, which is the counter whose encryption masks the final tag. A step advances the counter field by one for each further data block.

The widths are parameters, with defaults of 96 IV bits and 32 counter bits. The incrementer comes in two forms, picked by a parameter: a plain adder, or a chunked carry chain that splits the counter field into equal slices. The `upd_o` flag is high in each cycle in which the register has just been written by a command. Only 96-bit IVs are loaded directly. Other IV lengths and the cipher itself are handled elsewhere.

Top module: `gcm_ctr_gen`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `ctr_o` is all zeros and `upd_o` is 0.
- R2: A cycle with `clr_i` high makes `ctr_o` all zeros after the next rising clock edge.
- R3: A cycle with `ld_data_i` high, and `clr_i` low, makes `ctr_o` equal to {`iv_i`, counter field = 2} after the next edge. The IV occupies the upper IV_W bits and the counter field occupies the lower CTR_W bits.
- R4: A cycle with `ld_tag_i` high, and `clr_i` and `ld_data_i` low, makes `ctr_o` equal to {`iv_i`, counter field = 1} after the next edge.
- R5: A cycle in which `step_i` is the only command adds one to the lower CTR_W bits of `ctr_o` and leaves the upper IV_W bits unchanged.
- R6: A step from the all-ones counter field wraps that field to zero, and the IV bits stay unchanged.
- R7: When several commands are high together, the priority is clear, then data load, then tag load, then step.
- R8: In a cycle with no command high, `ctr_o` keeps its value, and `upd_o` is 0 in the following cycle.
- R9: `upd_o` is 1 in exactly those cycles that follow a cycle in which at least one command was high.
- R10: `iv_i` has no effect on `ctr_o` unless a data load or a tag load is the winning command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| clr_i | input | 1 | Clear the whole block to zero |
| ld_data_i | input | 1 | Load IV with the first data suffix (2) |
| ld_tag_i | input | 1 | Load IV with the tag suffix (1) |
| step_i | input | 1 | Increment the counter field |
| iv_i | input | IV_W | Initialization vector |
| ctr_o | output | IV_W+CTR_W | Current counter block |
| upd_o | output | 1 | Counter block written in the previous cycle |

## Verification
The interaction that matters most is between the commands, because any two or more of them can be raised in the same cycle. The priority sweep holds a known non-zero base value in the register. From that base it applies all sixteen combinations of the four command inputs, each with a fresh IV. The bench's own priority model predicts the result for each combination and is compared with `ctr_o` and `upd_o` one edge later. A second pair that can coincide is a step together with a changing IV. The bench drives new IV values during a run of steps that passes the wrap point, and judges that only the counter field moves.

// File: rtl/gcm_ctr_pkg.sv
package gcm_ctr_pkg;

   typedef enum logic [2:0] {
      OP_HOLD      = 3'd0,
      OP_CLEAR     = 3'd1,
      OP_LOAD_DATA = 3'd2,
      OP_LOAD_TAG  = 3'd3,
      OP_STEP      = 3'd4
   } ctr_op_e;

   function automatic logic op_writes(ctr_op_e op);
      return op != OP_HOLD;
   endfunction

endpackage

// File: rtl/gcm_ctr_arb.sv
module gcm_ctr_arb
   import gcm_ctr_pkg::*;
(
   input  logic    clr_i,
   input  logic    ld_data_i,
   input  logic    ld_tag_i,
   input  logic    step_i,
   output ctr_op_e op_o
);

   // Fixed priority: clear > data load > tag load > step (R7)
   always_comb begin
      if (clr_i)          op_o = OP_CLEAR;
      else if (ld_data_i) op_o = OP_LOAD_DATA;
      else if (ld_tag_i)  op_o = OP_LOAD_TAG;
      else if (step_i)    op_o = OP_STEP;
      else                op_o = OP_HOLD;
   end

   always_comb begin
      assert ($onehot0({clr_i, ld_data_i, ld_tag_i, step_i}) == 1'b0 ||
              op_o != OP_HOLD || !(clr_i | ld_data_i | ld_tag_i | step_i))
         else $error("a_r7_single_cmd_selected failed");
   end

endmodule

// File: rtl/gcm_ctr_inc.sv
module gcm_ctr_inc #(
   parameter int W       = 32,
   parameter int STYLE   = 1,
   parameter int CHUNK_W = 8
) (
   input  logic [W-1:0] val_i,
   output logic [W-1:0] val_o
);

   localparam int NCH = (STYLE == 1) ? (W / CHUNK_W) : 1;

   generate
      if (STYLE == 0) begin : g_adder
         assign val_o = val_i + W'(1);
      end else begin : g_chunked
         logic [NCH-1:0] cy;
         assign cy[0] = 1'b1;
         for (genvar k = 0; k < NCH; k++) begin : g_slice
            assign val_o[k*CHUNK_W +: CHUNK_W] =
               val_i[k*CHUNK_W +: CHUNK_W] + CHUNK_W'(cy[k]);
            if (k < NCH - 1) begin : g_carry
               assign cy[k+1] = cy[k] & (&val_i[k*CHUNK_W +: CHUNK_W]);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/gcm_ctr_reg.sv
module gcm_ctr_reg
   import gcm_ctr_pkg::*;
#(
   parameter int IV_W        = 96,
   parameter int CTR_W       = 32,
   parameter int DATA_SUFFIX = 2,
   parameter int TAG_SUFFIX  = 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  ctr_op_e               op_i,
   input  logic [IV_W-1:0]       iv_i,
   input  logic [CTR_W-1:0]      inc_i,
   output logic [IV_W+CTR_W-1:0] blk_o,
   output logic                  upd_o
);

   localparam int BLK_W = IV_W + CTR_W;
   localparam logic [CTR_W-1:0] DSUF = CTR_W'(DATA_SUFFIX);
   localparam logic [CTR_W-1:0] TSUF = CTR_W'(TAG_SUFFIX);

   logic [BLK_W-1:0] nxt;

   always_comb begin
      unique case (op_i)
         OP_CLEAR:     nxt = '0;
         OP_LOAD_DATA: nxt = {iv_i, DSUF};
         OP_LOAD_TAG:  nxt = {iv_i, TSUF};
         OP_STEP:      nxt = {blk_o[BLK_W-1:CTR_W], inc_i};
         default:      nxt = blk_o;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         blk_o <= '0;
         upd_o <= 1'b0;
      end else begin
         blk_o <= nxt;
         upd_o <= op_writes(op_i);
      end
   end

   // R6: a step never disturbs the IV bits, even on wrap
   a_r6_iv_kept_on_step: assert property (@(posedge clk) disable iff (!rst_n)
      op_i == OP_STEP |=> blk_o[BLK_W-1:CTR_W] == $past(blk_o[BLK_W-1:CTR_W]));

endmodule

// File: rtl/gcm_ctr_gen.sv
module gcm_ctr_gen
   import gcm_ctr_pkg::*;
#(
   parameter int IV_W        = 96,
   parameter int CTR_W       = 32,
   parameter int DATA_SUFFIX = 2,
   parameter int TAG_SUFFIX  = 1,
   parameter int INC_STYLE   = 1,
   parameter int CHUNK_W     = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr_i,
   input  logic                  ld_data_i,
   input  logic                  ld_tag_i,
   input  logic                  step_i,
   input  logic [IV_W-1:0]       iv_i,
   output logic [IV_W+CTR_W-1:0] ctr_o,
   output logic                  upd_o
);

   localparam int BLK_W = IV_W + CTR_W;

   generate
      if (CTR_W < 2) begin : g_chk_w
         $error("CTR_W must be at least 2");
      end
      if (DATA_SUFFIX == TAG_SUFFIX) begin : g_chk_suf
         $error("DATA_SUFFIX and TAG_SUFFIX must differ");
      end
      if (INC_STYLE == 1 && (CTR_W % CHUNK_W) != 0) begin : g_chk_chunk
         $error("CHUNK_W must divide CTR_W");
      end
      if (INC_STYLE != 0 && INC_STYLE != 1) begin : g_chk_style
         $error("INC_STYLE must be 0 or 1");
      end
   endgenerate

   ctr_op_e          op;
   logic [CTR_W-1:0] inc;

   gcm_ctr_arb u_arb (
      .clr_i     (clr_i),
      .ld_data_i (ld_data_i),
      .ld_tag_i  (ld_tag_i),
      .step_i    (step_i),
      .op_o      (op)
   );

   gcm_ctr_inc #(.W(CTR_W), .STYLE(INC_STYLE), .CHUNK_W(CHUNK_W)) u_inc (
      .val_i (ctr_o[CTR_W-1:0]),
      .val_o (inc)
   );

   gcm_ctr_reg #(
      .IV_W(IV_W), .CTR_W(CTR_W),
      .DATA_SUFFIX(DATA_SUFFIX), .TAG_SUFFIX(TAG_SUFFIX)
   ) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .op_i  (op),
      .iv_i  (iv_i),
      .inc_i (inc),
      .blk_o (ctr_o),
      .upd_o (upd_o)
   );

   a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> ctr_o == '0);

   a_r3_load_data: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && ld_data_i) |=> ctr_o == {$past(iv_i), CTR_W'(DATA_SUFFIX)});

   a_r4_load_tag: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !ld_data_i && ld_tag_i) |=>
         ctr_o == {$past(iv_i), CTR_W'(TAG_SUFFIX)});

   a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !ld_data_i && !ld_tag_i && step_i) |=>
         ctr_o[CTR_W-1:0] == CTR_W'($past(ctr_o[CTR_W-1:0]) + 1'b1));

   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(clr_i || ld_data_i || ld_tag_i || step_i) |=> $stable(ctr_o) && !upd_o);

   a_r9_upd: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i || ld_data_i || ld_tag_i || step_i) |=> upd_o);

   a_r1_reset: assert property (@(posedge clk)
      !rst_n |=> ctr_o == '0 && !upd_o);

   logic unused_blk;
   assign unused_blk = ^ctr_o[BLK_W-1:BLK_W-1];

endmodule

// File: tb/gcm_ctr_gen_bench.sv
`timescale 1ns/1ps
module gcm_ctr_gen_bench;

   localparam int IV_W  = 12;
   localparam int CTR_W = 4;
   localparam int BLK_W = IV_W + CTR_W;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             clr_i = 1'b0, ld_data_i = 1'b0, ld_tag_i = 1'b0, step_i = 1'b0;
   logic [IV_W-1:0]  iv_i = '0;
   logic [BLK_W-1:0] ctr_o;
   logic             upd_o;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;
   logic [BLK_W-1:0] model = '0;

   always #2 clk = ~clk;

   gcm_ctr_gen #(.IV_W(IV_W), .CTR_W(CTR_W), .DATA_SUFFIX(2), .TAG_SUFFIX(1),
                 .INC_STYLE(1), .CHUNK_W(2)) u_gcm_ctr_gen (
      .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .ld_data_i(ld_data_i),
      .ld_tag_i(ld_tag_i), .step_i(step_i), .iv_i(iv_i),
      .ctr_o(ctr_o), .upd_o(upd_o));

   task automatic chk(string req, logic [BLK_W-1:0] act, logic [BLK_W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Drive one cycle of commands, then compare with the bench model after the edge.
   task automatic cyc(string req, bit c, bit d, bit t, bit s, logic [IV_W-1:0] iv);
      logic [BLK_W-1:0] exp;
      @(negedge clk);
      clr_i = c; ld_data_i = d; ld_tag_i = t; step_i = s; iv_i = iv;
      if (c)      exp = '0;
      else if (d) exp = {iv, 4'd2};
      else if (t) exp = {iv, 4'd1};
      else if (s) exp = {model[BLK_W-1:CTR_W], model[CTR_W-1:0] + 4'd1};
      else        exp = model;
      @(posedge clk);
      #1;
      model = exp;
      chk(req, ctr_o, exp);
      chk({req, " upd"}, {15'd0, upd_o}, {15'd0, (c | d | t | s)});
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      // R1: reset state, with commands high that must be overridden
      clr_i = 1'b0; ld_data_i = 1'b1; step_i = 1'b1; iv_i = 12'hABC;
      repeat (3) @(posedge clk);
      #1;
      chk("R1 ctr", ctr_o, '0);
      chk("R1 upd", {15'd0, upd_o}, '0);
      @(negedge clk);
      ld_data_i = 1'b0; step_i = 1'b0;
      rst_n = 1'b1;
      @(posedge clk); #1;
      chk("R1 after release", ctr_o, '0);
      chk("R1 upd after release", {15'd0, upd_o}, '0);

      // R3: data load over several IVs
      for (int i = 0; i < 6; i++) cyc("R3 load data", 0, 1, 0, 0, 12'(i * 12'h2D7 + 1));

      // R8: hold, with IV changing (R10)
      cyc("R8 hold", 0, 0, 0, 0, 12'h555);
      cyc("R10 hold iv ignored", 0, 0, 0, 0, 12'hAAA);

      // R5/R6/R10: step through the wrap while IV wiggles
      cyc("R3 base", 0, 1, 0, 0, 12'h9C3);
      for (int i = 0; i < 20; i++) begin
         if (model[CTR_W-1:0] == 4'hF) cyc("R6 wrap", 0, 0, 0, 1, 12'(i * 37));
         else                          cyc("R5 R10 step", 0, 0, 0, 1, 12'(i * 37));
      end

      // R4: tag load over several IVs
      for (int i = 0; i < 6; i++) cyc("R4 load tag", 0, 0, 1, 0, 12'(12'hF00 - i * 12'h111));

      // R2: clear from non-zero
      cyc("R2 clear", 1, 0, 0, 0, 12'h123);
      cyc("R2 step after clear", 0, 0, 0, 1, 12'h321);
      cyc("R2 clear again", 1, 0, 0, 0, 12'h777);

      // R7/R9: every command combination from a known base
      for (int m = 0; m < 16; m++) begin
         cyc("R7 base", 0, 1, 0, 0, 12'h5A5);
         cyc("R7 R9 combo", m[3], m[2], m[1], m[0], 12'(12'h0F1 + m * 12'h13));
         cyc("R9 idle", 0, 0, 0, 0, 12'h000);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule